// File: doc/BRIEF.md
# Protected Clock Control Register Unit

This unit is an 8-bit clock control and status register on a simple synchronous register bus. Its 4-bit command field can only be written inside a short unlock window. Software opens the window by writing a single unlock pattern. The next write then sets the command field. That write can ask the clock-availability logic to check a source, ask it to switch a source on, or arm a prescaler reload.

A ready flag shows the state of the availability handshake. It clears when a check or enable command is accepted. It sets once the external logic reports that the source is running and stable, which can take any number of cycles.

The unit also drives a power-of-two clock-enable generator that divides by 1 to 256.

Top module: `clkctl_guard`

## Requirements
- R1: After reset the register reads 0x00, both request outputs are low, and `div_ce` is high every cycle (divide by 1).
- R2: The unlock flag (read bit 7) is set only by a write of exactly 0x80 while the window is closed. Any other write while closed leaves bit 7 at 0.
- R3: Once opened, the window reads 1 on bit 7 for exactly four cycles and then clears by itself.
- R4: Writing 0x80 again while the window is open is ignored. It neither restarts the four-cycle count nor closes the window.
- R5: Any write other than 0x80 while the window is open is accepted, and bit 7 reads 0 from the next cycle on.
- R6: Bits 3:0 read back the low nibble of the last accepted write. Writes while the window is closed leave them unchanged.
- R7: Bits 6:5 always read 0.
- R8: An accepted value of 0x1 in bits 3:0 gives a one-cycle `chk_req` pulse in the next cycle. An accepted value of 0x2 gives a one-cycle `src_on_req` pulse. Either one clears the ready flag (bit 4) on the same edge.
- R9: After a 0x1 or 0x2 command, the ready flag sets on the first later edge where `src_stable` is high. It stays set until the next such command. It never sets without a pending command.
- R10: An accepted value of 0x3 arms a divider load. The next accepted write loads its bits 3:0 as the divider code and is not decoded as a command.
- R11: With divider code c from 0 to 8, `div_ce` pulses once every 2^c cycles. Codes 9 to 15 give a pulse every cycle.
- R12: A new divider code takes effect only when the running count reaches zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read value {unlock, 0, 0, ready, field} |
| chk_req | output | 1 | One-cycle request to check source availability |
| src_on_req | output | 1 | One-cycle request to switch the source on |
| src_stable | input | 1 | Availability logic reports that the source is running and stable |
| div_ce | output | 1 | Prescaler clock-enable pulse |

## Verification
A window counter that is off by one shows on read bit 7 within five cycles of the unlock write. It also shows up as a command that is accepted or dropped on the wrong cycle.

A wrong arm or pending state appears one cycle after the accepted write. The symptom is a request pulse where none should be, or a missing one. A stale pending state makes the ready flag rise without a request.

Prescaler faults appear as a wrong gap between `div_ce` pulses. They are visible within one full period of the new code, so within at most 512 cycles of the load.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
   localparam int REG_W   = 8;
   localparam int FIELD_W = 4;

   typedef enum logic [FIELD_W-1:0] {
      CMD_NOP      = 4'h0,
      CMD_CHECK    = 4'h1,
      CMD_SRC_ON   = 4'h2,
      CMD_LOAD_DIV = 4'h3
   } cmd_e;

   typedef struct packed {
      logic               unlock;
      logic [1:0]         rsv;
      logic               ready;
      logic [FIELD_W-1:0] field;
   } csr_t;
endpackage

// File: rtl/clkctl_window.sv
module clkctl_window #(
   parameter int WINDOW = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_hit,
   input  logic ctrl_hit,
   output logic open
);
   localparam int CW = (WINDOW > 1) ? $clog2(WINDOW) : 1;
   localparam int AW = $clog2(WINDOW + 1) + 1;

   if (WINDOW < 1) begin : g_bad_window
      $error("clkctl_window: WINDOW must be at least 1");
   end

   logic [CW-1:0] left;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open <= 1'b0;
         left <= '0;
      end else if (!open) begin
         if (arm_hit) begin
            open <= 1'b1;
            left <= CW'(WINDOW - 1);
         end
      end else if (ctrl_hit) begin
         open <= 1'b0;
      end else if (left == '0) begin
         open <= 1'b0;
      end else begin
         left <= left - 1'b1;
      end
   end

   // checker-side age counter for the open window
   logic [AW-1:0] age;
   always_ff @(posedge clk) begin
      if (!rst_n)    age <= '0;
      else if (open) age <= age + 1'b1;
      else           age <= '0;
   end

   assert_open_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(open) |-> $past(arm_hit));
   assert_window_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
      open |-> (age < AW'(WINDOW)));
   assert_rearm_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (open && arm_hit && left != '0) |=> open);
   assert_ctrl_close_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (open && ctrl_hit) |=> !open);
endmodule

// File: rtl/clkctl_cmd.sv
module clkctl_cmd
   import clkctl_pkg::*;
#(
   parameter int SYNC_STAGES = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               accept,
   input  logic [FIELD_W-1:0] wfield,
   input  logic               src_stable,
   output logic [FIELD_W-1:0] field_q,
   output logic               ready_q,
   output logic               chk_pulse,
   output logic               on_pulse,
   output logic               div_load,
   output logic [FIELD_W-1:0] div_code
);
   if (SYNC_STAGES < 0) begin : g_bad_sync
      $error("clkctl_cmd: SYNC_STAGES must not be negative");
   end

   logic stable_s;

   if (SYNC_STAGES == 0) begin : g_direct
      assign stable_s = src_stable;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sh;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            sh <= '0;
         end else begin
            sh[0] <= src_stable;
            for (int i = 1; i < SYNC_STAGES; i++) sh[i] <= sh[i-1];
         end
      end
      assign stable_s = sh[SYNC_STAGES-1];
   end

   logic arm_q, pend_q;
   logic is_chk, is_on, is_ld, req_cmd;

   always_comb begin
      is_chk  = accept && !arm_q && (wfield == CMD_CHECK);
      is_on   = accept && !arm_q && (wfield == CMD_SRC_ON);
      is_ld   = accept && !arm_q && (wfield == CMD_LOAD_DIV);
      req_cmd = is_chk || is_on;
   end

   assign div_load = accept && arm_q;
   assign div_code = wfield;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         field_q   <= '0;
         ready_q   <= 1'b0;
         pend_q    <= 1'b0;
         arm_q     <= 1'b0;
         chk_pulse <= 1'b0;
         on_pulse  <= 1'b0;
      end else begin
         chk_pulse <= is_chk;
         on_pulse  <= is_on;
         if (accept) field_q <= wfield;
         if (div_load)   arm_q <= 1'b0;
         else if (is_ld) arm_q <= 1'b1;
         if (req_cmd) begin
            ready_q <= 1'b0;
            pend_q  <= 1'b1;
         end else if (pend_q && stable_s) begin
            ready_q <= 1'b1;
            pend_q  <= 1'b0;
         end
      end
   end

   assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_pulse || on_pulse) |=> !(chk_pulse || on_pulse) || $past(req_cmd));
   assert_ready_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_pulse || on_pulse) |-> !ready_q);
   assert_field_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !accept |=> $stable(field_q));
   assert_ready_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready_q) |-> $past(stable_s && pend_q));
   assert_load_nocmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
      div_load |=> !(chk_pulse || on_pulse));
endmodule

// File: rtl/clkctl_presc.sv
module clkctl_presc #(
   parameter int CODE_W   = 4,
   parameter int MAX_CODE = 8,
   parameter bit RSV_DIV1 = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [CODE_W-1:0] code_in,
   output logic              div_ce
);
   localparam int CNT_W      = (MAX_CODE > 0) ? MAX_CODE : 1;
   localparam int PERIOD_MAX = 1 << MAX_CODE;

   if (MAX_CODE < 1 || (1 << CODE_W) <= MAX_CODE) begin : g_bad_code
      $error("clkctl_presc: MAX_CODE must be 1..2**CODE_W-1");
   end

   logic [CODE_W-1:0] code_q;
   logic [CNT_W-1:0]  cnt, lim;
   logic [CNT_W:0]    pow;
   logic              code_ok;

   always_comb begin
      pow     = {{CNT_W{1'b0}}, 1'b1} << code_q;
      code_ok = (code_q <= CODE_W'(MAX_CODE));
   end

   if (RSV_DIV1) begin : g_rsv_div1
      always_comb lim = code_ok ? (pow[CNT_W-1:0] - 1'b1) : '0;
   end else begin : g_rsv_clamp
      always_comb lim = code_ok ? (pow[CNT_W-1:0] - 1'b1) : '1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         code_q <= '0;
         cnt    <= '0;
      end else begin
         if (load) code_q <= code_in;
         if (cnt == '0) cnt <= lim;
         else           cnt <= cnt - 1'b1;
      end
   end

   assign div_ce = (cnt == '0);

   // checker-side gap counter
   logic [CNT_W:0] gap;
   always_ff @(posedge clk) begin
      if (!rst_n)      gap <= '0;
      else if (div_ce) gap <= '0;
      else             gap <= gap + 1'b1;
   end

   assert_period_cap_R11: assert property (@(posedge clk) disable iff (!rst_n)
      gap <= (CNT_W+1)'(PERIOD_MAX - 1));
   assert_wrap_only_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !div_ce |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/clkctl_guard.sv
module clkctl_guard
   import clkctl_pkg::*;
#(
   parameter int WINDOW      = 4,
   parameter int MAX_CODE    = 8,
   parameter int SYNC_STAGES = 0,
   parameter bit RSV_DIV1    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_we,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   output logic             chk_req,
   output logic             src_on_req,
   input  logic             src_stable,
   output logic             div_ce
);
   localparam logic [REG_W-1:0] UNLOCK_PAT = REG_W'(1) << (REG_W - 1);

   if ($bits(csr_t) != REG_W) begin : g_bad_layout
      $error("clkctl_guard: register layout does not match REG_W");
   end

   logic               unlock_pat, arm_hit, ctrl_hit, open, accept;
   logic [FIELD_W-1:0] field_q, div_code;
   logic               ready_q, div_load;
   csr_t               rd;

   always_comb begin
      unlock_pat = (reg_wdata == UNLOCK_PAT);
      arm_hit    = reg_we && unlock_pat;
      ctrl_hit   = reg_we && !unlock_pat;
      accept     = ctrl_hit && open;
   end

   clkctl_window #(.WINDOW(WINDOW)) u_win (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm_hit  (arm_hit),
      .ctrl_hit (ctrl_hit),
      .open     (open)
   );

   clkctl_cmd #(.SYNC_STAGES(SYNC_STAGES)) u_cmd (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (accept),
      .wfield     (reg_wdata[FIELD_W-1:0]),
      .src_stable (src_stable),
      .field_q    (field_q),
      .ready_q    (ready_q),
      .chk_pulse  (chk_req),
      .on_pulse   (src_on_req),
      .div_load   (div_load),
      .div_code   (div_code)
   );

   clkctl_presc #(.CODE_W(FIELD_W), .MAX_CODE(MAX_CODE), .RSV_DIV1(RSV_DIV1)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (div_load),
      .code_in (div_code),
      .div_ce  (div_ce)
   );

   always_comb begin
      rd.unlock = open;
      rd.rsv    = '0;
      rd.ready  = ready_q;
      rd.field  = field_q;
   end
   assign reg_rdata = rd;

   assert_closed_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && !open && !unlock_pat) |=> $stable(reg_rdata[FIELD_W-1:0]));
   assert_closed_nopulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && !open) |=> !(chk_req || src_on_req));
endmodule

// File: tb/sim_clkctl_guard.sv
module sim_clkctl_guard;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       we = 1'b0;
   logic [7:0] wd = 8'h00;
   logic       stb = 1'b0;
   logic [7:0] rdata;
   logic       chk_req, on_req, ce;

   always #10 clk = ~clk;

   clkctl_guard u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_we     (we),
      .reg_wdata  (wd),
      .reg_rdata  (rdata),
      .chk_req    (chk_req),
      .src_on_req (on_req),
      .src_stable (stb),
      .div_ce     (ce)
   );

   int n_chk = 0;
   int n_fail = 0;

   // requirement-level model state
   bit       m_open, m_arm, m_pend, m_ready, m_pa, m_pe;
   int       m_left;
   bit [3:0] m_field, m_code;

   function automatic int div_of(input int c);
      return (c <= 8) ? (1 << c) : 1;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic model_edge(input bit w, input bit [7:0] d, input bit s);
      bit acc, req;
      acc  = w && m_open && (d != 8'h80);
      req  = acc && !m_arm && (d[3:0] == 4'h1 || d[3:0] == 4'h2);
      m_pa = acc && !m_arm && (d[3:0] == 4'h1);
      m_pe = acc && !m_arm && (d[3:0] == 4'h2);
      if (!m_open) begin
         if (w && d == 8'h80) begin m_open = 1; m_left = 3; end
      end else if (acc) m_open = 0;
      else if (m_left == 0) m_open = 0;
      else m_left--;
      if (acc) begin
         m_field = d[3:0];
         if (m_arm) begin m_code = d[3:0]; m_arm = 0; end
         else if (d[3:0] == 4'h3) m_arm = 1;
      end
      if (req) begin m_ready = 0; m_pend = 1; end
      else if (m_pend && s) begin m_ready = 1; m_pend = 0; end
   endtask

   task automatic step(input bit w, input bit [7:0] d, input bit s);
      we = w; wd = d; stb = s;
      @(posedge clk);
      model_edge(w, d, s);
      @(negedge clk);
      we = 1'b0;
      chk(rdata[7] == m_open, "R3 unlock bit", rdata[7], m_open);
      chk(rdata[6:5] == 2'b00, "R7 reserved bits", rdata[6:5], 0);
      chk(rdata[4] == m_ready, "R9 ready flag", rdata[4], m_ready);
      chk(rdata[3:0] == m_field, "R6 field", rdata[3:0], m_field);
      chk(chk_req == m_pa, "R8 check pulse", chk_req, m_pa);
      chk(on_req == m_pe, "R8 enable pulse", on_req, m_pe);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 8'h00, stb);
   endtask

   task automatic load_code(input bit [3:0] c);
      step(1'b1, 8'h80, 1'b0);
      step(1'b1, 8'h03, 1'b0);
      step(1'b1, 8'h80, 1'b0);
      step(1'b1, {4'h0, c}, 1'b0);
      chk(!chk_req && !on_req, "R10 load not decoded", {chk_req, on_req}, 0);
   endtask

   task automatic measure(input int exp, input string tag);
      int g;
      idle(300);
      for (int i = 0; i < 600 && !ce; i++) idle(1);
      g = 0;
      for (int i = 0; i < 600; i++) begin
         idle(1);
         g++;
         if (ce) break;
      end
      chk(g == exp, tag, g, exp);
   endtask

   initial begin
      #(20 * 150000);
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk(rdata == 8'h00, "R1 reset read", rdata, 0);
      chk(ce == 1'b1, "R1 reset divide by 1", ce, 1);
      chk(!chk_req && !on_req, "R1 reset requests", {chk_req, on_req}, 0);
      idle(1);
      chk(ce == 1'b1, "R1 ce every cycle", ce, 1);

      // R2: only the exact pattern opens the window
      step(1'b1, 8'h81, 1'b0);
      chk(rdata[7] == 1'b0, "R2 near pattern ignored", rdata[7], 0);
      step(1'b1, 8'h80, 1'b0);
      chk(rdata[7] == 1'b1, "R2 pattern opens", rdata[7], 1);
      // R3: four cycles open
      idle(3);
      chk(rdata[7] == 1'b1, "R3 still open", rdata[7], 1);
      idle(1);
      chk(rdata[7] == 1'b0, "R3 timed close", rdata[7], 0);

      // R4: rewrite does not extend
      step(1'b1, 8'h80, 1'b0);
      idle(1);
      step(1'b1, 8'h80, 1'b0);
      chk(rdata[7] == 1'b1, "R4 rewrite keeps open", rdata[7], 1);
      idle(1);
      chk(rdata[7] == 1'b1, "R4 last open cycle", rdata[7], 1);
      idle(1);
      chk(rdata[7] == 1'b0, "R4 no extension", rdata[7], 0);

      // R5, R8, R9: check command and ready handshake
      step(1'b1, 8'h80, 1'b0);
      step(1'b1, 8'h01, 1'b0);
      chk(rdata[7] == 1'b0, "R5 close on control write", rdata[7], 0);
      chk(chk_req == 1'b1, "R8 check pulse", chk_req, 1);
      idle(3);
      chk(rdata[4] == 1'b0, "R9 wait for stable", rdata[4], 0);
      step(1'b0, 8'h00, 1'b1);
      chk(rdata[4] == 1'b1, "R9 ready set", rdata[4], 1);
      step(1'b1, 8'h80, 1'b1);
      step(1'b1, 8'h02, 1'b1);
      chk(on_req == 1'b1 && rdata[4] == 1'b0, "R8 enable clears ready", {on_req, rdata[4]}, 2);
      step(1'b0, 8'h00, 1'b1);
      chk(rdata[4] == 1'b1, "R9 ready after enable", rdata[4], 1);

      // R6: closed write ignored
      step(1'b1, 8'h07, 1'b0);
      chk(rdata[3:0] == 4'h2, "R6 closed write ignored", rdata[3:0], 2);

      // R10, R11, R12: divider codes
      load_code(4'h5);
      measure(32, "R10 loaded code 5 period");
      load_code(4'h0);
      measure(1, "R11 code 0 period");
      load_code(4'h3);
      measure(8, "R11 code 3 period");
      load_code(4'h8);
      measure(256, "R12 code 8 period");
      load_code(4'h9);
      measure(1, "R11 reserved 9 period");
      load_code(4'hF);
      measure(1, "R11 reserved 15 period");

      // constrained random mix
      void'($urandom(32'h5EED_0C1C));
      for (int i = 0; i < 500; i++) begin
         int op;
         bit [7:0] d;
         bit s;
         op = $urandom_range(0, 9);
         s  = 1'($urandom_range(0, 1));
         d  = 8'($urandom_range(0, 255));
         if (op < 3) step(1'b1, 8'h80, s);
         else if (op < 5) step(1'b1, {d[7:4], 2'b00, d[1:0]}, s);
         else if (op < 7) step(1'b1, d, s);
         else step(1'b0, 8'h00, s);
      end
      stb = 1'b0;
      measure(div_of(m_code), "R11 random final period");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule